// File: doc/BRIEF.md
# Flat Page Table Walker

This block turns a virtual page number into a physical page number by fetching a single entry from a one-level page table that lives in main memory. The table is indexed directly by the virtual page number. Its start address comes from a base input that software holds in a dedicated register. A second input gives the highest page number the table covers. A request above that bound is rejected before any memory traffic is issued.

An accepted request is handled in fixed steps. The block first checks the bound. It then reads the 32-bit entry at `base + vpn*4` and decides the outcome from the entry's valid and write-protect bits. When the access is allowed, the block keeps the in-memory use-tracking bits up to date. It writes the entry back with the reference bit set, and with the dirty bit also set on a write. This write-back is skipped when those bits already hold their required values. A missing page raises a one-cycle fault pulse for the processor's interrupt logic. The request, memory and response sides each use a valid/ready handshake, and only one walk is in flight at a time.

Entry layout, bit 31 down to bit 0: valid (31), dirty (30), reference (29), write-protect (28), reserved (27 down to PPN_W), physical page number (PPN_W-1:0). The response status codes are: 0 ok, 1 page fault, 2 protection fault, 3 out of range.

Top module: `pt_walker`

## Requirements
- R1: For an in-range request, the block issues exactly one memory read (`mem_req_we_o`=0) at address `pt_base_i + req_vpn_i*4`.
- R2: A request with `req_vpn_i` greater than `pt_limit_i` gets status 3 and PPN 0, and issues no memory request. A page number equal to the limit is walked normally.
- R3: An entry with bit 31 (valid) at 0 gets status 1 and PPN 0, and causes no write-back. `pf_irq_o` is high for exactly one cycle, and that cycle is the first cycle of the response.
- R4: An allowed access gets status 0 and returns bits PPN_W-1:0 of the entry as `rsp_ppn_o`. Any fault status returns PPN 0.
- R5: An allowed access to an entry whose bit 29 (reference) is 0 writes the entry back to the same address with bit 29 set. All other bits keep their values, except as stated in R6.
- R6: An allowed write request to an entry whose bit 30 (dirty) is 0 writes back with bits 30 and 29 both set. A read request never sets bit 30.
- R7: No write-back is issued when bit 29 is already 1 and the request is either a read or finds bit 30 already 1.
- R8: A write request to an entry whose bit 28 (write-protect) is 1 gets status 2 and PPN 0, and leaves the entry in memory unchanged. A read of such a page is allowed.
- R9: `mem_req_*` and `rsp_*` outputs hold steady while their valid is high and ready is low. `req_ready_o` is high only while no walk is in progress.
- R10: After reset, `req_ready_o` is 1, and `rsp_valid_o`, `mem_req_valid_o` and `pf_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_write_i | input | 1 | Request is a store access |
| pt_base_i | input | PA_W | Byte address of the page table |
| pt_limit_i | input | VPN_W | Highest legal virtual page number |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result accepted |
| rsp_status_o | output | 2 | 0 ok, 1 page fault, 2 protection fault, 3 out of range |
| rsp_ppn_o | output | PPN_W | Physical page number, 0 on fault |
| pf_irq_o | output | 1 | One-cycle page-fault pulse |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | PA_W | Byte address of the entry |
| mem_req_wdata_o | output | 32 | Updated entry on writes |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 32 | Read entry |

## Verification
The bench targets these corner cases:
- A page number exactly at the limit and one just above it. An off-by-one compare would either fault a legal page or read past the table.
- Reads and writes to entries whose reference and dirty bits are already set. A design that always writes back would show an extra memory write.
- A read to a clean page. A design that set the dirty bit on reads would corrupt the entry.
- A store to a write-protected page. This must leave memory untouched and return no translation.
- A walk with a stalling memory and a late response consumer. A design that dropped or changed its request or response under back-pressure would give a wrong translation or issue a duplicate access.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int PTE_W      = 32;
  localparam int PTE_V_BIT  = 31;
  localparam int PTE_D_BIT  = 30;
  localparam int PTE_R_BIT  = 29;
  localparam int PTE_WP_BIT = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK_LIMIT,
    ST_READ_REQ,
    ST_READ_WAIT,
    ST_UPDATE_WRITE,
    ST_RESPOND
  } pw_state_e;

  typedef enum logic [1:0] {
    PW_OK         = 2'd0,
    PW_PAGE_FAULT = 2'd1,
    PW_PROT_FAULT = 2'd2,
    PW_RANGE      = 2'd3
  } pw_status_e;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int VPN_W = 21,
  parameter int PA_W  = 32
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [VPN_W-1:0] limit_i,
  output logic [PA_W-1:0]  addr_o,
  output logic             over_limit_o
);
  localparam int ENTRY_SHIFT = $clog2(pw_pkg::PTE_W / 8);

  logic [PA_W-1:0] vpn_ext;

  assign vpn_ext      = PA_W'(vpn_i);
  assign addr_o       = base_i + (vpn_ext << ENTRY_SHIFT);
  assign over_limit_o = vpn_i > limit_i;
endmodule

// File: rtl/pw_pte_eval.sv
module pw_pte_eval
  import pw_pkg::*;
#(
  parameter int PPN_W = 21
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             is_write_i,
  output pw_status_e       status_o,
  output logic             need_wb_o,
  output logic [PTE_W-1:0] wb_data_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic allowed;

  always_comb begin
    if (!pte_i[PTE_V_BIT])                      status_o = PW_PAGE_FAULT;
    else if (is_write_i && pte_i[PTE_WP_BIT])   status_o = PW_PROT_FAULT;
    else                                        status_o = PW_OK;
  end

  assign allowed   = (status_o == PW_OK);
  // write-back only when a tracking bit actually changes
  assign need_wb_o = allowed && (!pte_i[PTE_R_BIT] || (is_write_i && !pte_i[PTE_D_BIT]));

  always_comb begin
    wb_data_o = pte_i;
    wb_data_o[PTE_R_BIT] = 1'b1;
    if (is_write_i) wb_data_o[PTE_D_BIT] = 1'b1;
  end

  assign ppn_o = allowed ? pte_i[PPN_W-1:0] : '0;
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  logic      over_limit_i,
  input  logic      mem_req_ready_i,
  input  logic      mem_rsp_valid_i,
  input  logic      need_wb_i,
  input  logic      rsp_ready_i,
  output pw_state_e state_o
);
  pw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:         if (req_valid_i) state_d = ST_CHECK_LIMIT;
      ST_CHECK_LIMIT:  state_d = over_limit_i ? ST_RESPOND : ST_READ_REQ;
      ST_READ_REQ:     if (mem_req_ready_i) state_d = ST_READ_WAIT;
      ST_READ_WAIT:    if (mem_rsp_valid_i) state_d = need_wb_i ? ST_UPDATE_WRITE : ST_RESPOND;
      ST_UPDATE_WRITE: if (mem_req_ready_i) state_d = ST_RESPOND;
      ST_RESPOND:      if (rsp_ready_i) state_d = ST_IDLE;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int VPN_W = 21,
  parameter int OFF_W = 11,
  parameter int PA_W  = 32,
  parameter int PPN_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             req_write_i,
  input  logic [PA_W-1:0]  pt_base_i,
  input  logic [VPN_W-1:0] pt_limit_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [1:0]       rsp_status_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             pf_irq_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic             mem_req_we_o,
  output logic [PA_W-1:0]  mem_req_addr_o,
  output logic [31:0]      mem_req_wdata_o,
  input  logic             mem_rsp_valid_i,
  input  logic [31:0]      mem_rsp_rdata_i
);
  // virtual address width implied by the split; page offset is not used here
  localparam int VA_W = VPN_W + OFF_W;

  pw_state_e        state;
  logic [VPN_W-1:0] vpn_q, limit_q;
  logic [PA_W-1:0]  base_q;
  logic             wr_q;
  logic [PTE_W-1:0] wb_q;
  pw_status_e       status_q;
  logic [PPN_W-1:0] ppn_q;
  logic             irq_q;

  logic [PA_W-1:0]  entry_addr;
  logic             over_limit;
  pw_status_e       eval_status;
  logic             need_wb;
  logic [PTE_W-1:0] wb_data;
  logic [PPN_W-1:0] eval_ppn;
  logic             accept, rd_done;

  pw_addr_gen #(.VPN_W(VPN_W), .PA_W(PA_W)) u_addr (
    .base_i      (base_q),
    .vpn_i       (vpn_q),
    .limit_i     (limit_q),
    .addr_o      (entry_addr),
    .over_limit_o(over_limit)
  );

  pw_pte_eval #(.PPN_W(PPN_W)) u_eval (
    .pte_i     (mem_rsp_rdata_i),
    .is_write_i(wr_q),
    .status_o  (eval_status),
    .need_wb_o (need_wb),
    .wb_data_o (wb_data),
    .ppn_o     (eval_ppn)
  );

  pw_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .over_limit_i   (over_limit),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .need_wb_i      (need_wb),
    .rsp_ready_i    (rsp_ready_i),
    .state_o        (state)
  );

  assign accept  = (state == ST_IDLE) && req_valid_i;
  assign rd_done = (state == ST_READ_WAIT) && mem_rsp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q   <= '0;
      limit_q <= '0;
      base_q  <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      vpn_q   <= req_vpn_i;
      limit_q <= pt_limit_i;
      base_q  <= pt_base_i;
      wr_q    <= req_write_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= PW_OK;
      ppn_q    <= '0;
      wb_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= rd_done && (eval_status == PW_PAGE_FAULT);
      if (state == ST_CHECK_LIMIT && over_limit) begin
        status_q <= PW_RANGE;
        ppn_q    <= '0;
      end else if (rd_done) begin
        status_q <= eval_status;
        ppn_q    <= eval_ppn;
        wb_q     <= wb_data;
      end
    end
  end

  assign req_ready_o     = (state == ST_IDLE);
  assign mem_req_valid_o = (state == ST_READ_REQ) || (state == ST_UPDATE_WRITE);
  assign mem_req_we_o    = (state == ST_UPDATE_WRITE);
  assign mem_req_addr_o  = entry_addr;
  assign mem_req_wdata_o = (state == ST_UPDATE_WRITE) ? wb_q : '0;
  assign rsp_valid_o     = (state == ST_RESPOND);
  assign rsp_status_o    = status_q;
  assign rsp_ppn_o       = ppn_q;
  assign pf_irq_o        = irq_q;
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int VPN_W = 21,
  parameter int PA_W  = 32,
  parameter int PPN_W = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [1:0]       rsp_status_o,
  input logic [PPN_W-1:0] rsp_ppn_o,
  input logic             pf_irq_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic             mem_req_we_o,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic [31:0]      mem_req_wdata_o,
  input logic [VPN_W-1:0] vpn_q,
  input logic [VPN_W-1:0] limit_q
);
  AST_RANGE_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> vpn_q <= limit_q); // R2

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_irq_o |=> !pf_irq_o); // R3

  AST_IRQ_WITH_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_irq_o |-> rsp_valid_o && rsp_status_o == 2'd1); // R3

  AST_FAULT_NO_PPN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_status_o != 2'd0 |-> rsp_ppn_o == '0); // R4

  AST_WB_SETS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o[31] && mem_req_wdata_o[29]); // R5

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_we_o)
      && $stable(mem_req_addr_o) && $stable(mem_req_wdata_o)); // R9

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_status_o)
      && $stable(rsp_ppn_o)); // R9

  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rsp_valid_o && !mem_req_valid_o); // R9
endmodule

bind pt_walker pw_checker #(.VPN_W(VPN_W), .PA_W(PA_W), .PPN_W(PPN_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_ready_i    (rsp_ready_i),
  .rsp_status_o   (rsp_status_o),
  .rsp_ppn_o      (rsp_ppn_o),
  .pf_irq_o       (pf_irq_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_we_o   (mem_req_we_o),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o),
  .vpn_q          (vpn_q),
  .limit_q        (limit_q)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int VPN_W = 21;
  localparam int PA_W  = 32;
  localparam int PPN_W = 21;
  localparam logic [31:0] BASE = 32'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0, pt_limit = 21'd40;
  logic rsp_valid, rsp_ready = 1'b0, pf_irq;
  logic [1:0] rsp_status;
  logic [PPN_W-1:0] rsp_ppn;
  logic mem_valid, mem_ready = 1'b0, mem_we, mem_rvalid = 1'b0;
  logic [PA_W-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  logic [31:0] mem [0:511];
  int rd_cnt = 0, wr_cnt = 0, irq_cnt = 0, cyc = 0;
  logic [31:0] last_raddr = '0, last_waddr = '0, last_wdata = '0;
  bit stall = 1'b0;
  bit hs_pend = 1'b0, hs_we = 1'b0;
  logic [31:0] hs_addr = '0, hs_wdata = '0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pt_walker #(.VPN_W(VPN_W), .OFF_W(11), .PA_W(PA_W), .PPN_W(PPN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vpn_i(req_vpn),
    .req_write_i(req_write), .pt_base_i(BASE), .pt_limit_i(pt_limit),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_status_o(rsp_status),
    .rsp_ppn_o(rsp_ppn), .pf_irq_o(pf_irq),
    .mem_req_valid_o(mem_valid), .mem_req_ready_i(mem_ready), .mem_req_we_o(mem_we),
    .mem_req_addr_o(mem_addr), .mem_req_wdata_o(mem_wdata),
    .mem_rsp_valid_i(mem_rvalid), .mem_rsp_rdata_i(mem_rdata)
  );

  // memory model: acts at negedge on handshakes that completed at the previous posedge
  always @(negedge clk) begin
    if (rst_n) begin
      mem_rvalid = 1'b0;
      if (pf_irq) irq_cnt++;
      if (hs_pend) begin
        if (hs_we) begin
          mem[hs_addr[10:2]] = hs_wdata;
          wr_cnt++;
          last_waddr = hs_addr;
          last_wdata = hs_wdata;
        end else begin
          mem_rdata  = mem[hs_addr[10:2]];
          mem_rvalid = 1'b1;
          rd_cnt++;
          last_raddr = hs_addr;
        end
      end
      cyc++;
      mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
      hs_pend   = mem_valid && mem_ready;
      hs_we     = mem_we;
      hs_addr   = mem_addr;
      hs_wdata  = mem_wdata;
    end
  end

  function automatic logic [31:0] pte(bit v, bit d, bit r, bit wp, logic [20:0] ppn);
    return {v, d, r, wp, 7'h0, ppn};
  endfunction

  function automatic logic [31:0] slot(logic [VPN_W-1:0] vpn);
    return BASE + {11'h0, vpn} * 4;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic walk(input logic [VPN_W-1:0] vpn, input bit wr, input int rsp_delay,
                      output logic [1:0] st, output logic [PPN_W-1:0] ppn,
                      output int nrd, output int nwr, output int nirq);
    int rd0 = rd_cnt, wr0 = wr_cnt, irq0 = irq_cnt, n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = vpn; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    if (!rsp_valid) check("R9", "response timeout", 0, 1);
    st = rsp_status; ppn = rsp_ppn;
    for (int i = 0; i < rsp_delay; i++) begin
      @(negedge clk);
      check("R9", "rsp held", {29'h0, rsp_valid, rsp_status}, {29'h0, 1'b1, st});
      check("R9", "ppn held", {11'h0, rsp_ppn}, {11'h0, ppn});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    @(negedge clk);
    check("R9", "ready after walk", {31'h0, req_ready}, 32'd1);
    nrd = rd_cnt - rd0; nwr = wr_cnt - wr0; nirq = irq_cnt - irq0;
  endtask

  task automatic t_reset();
    check("R10", "req_ready", {31'h0, req_ready}, 32'd1);
    check("R10", "rsp_valid", {31'h0, rsp_valid}, 32'd0);
    check("R10", "mem_valid", {31'h0, mem_valid}, 32'd0);
    check("R10", "pf_irq", {31'h0, pf_irq}, 32'd0);
  endtask

  task automatic t_read_ref();
    logic [1:0] st; logic [PPN_W-1:0] p; int r, w, q;
    mem[slot(3) >> 2] = pte(1, 0, 0, 0, 21'h1ABCD);
    walk(3, 0, 0, st, p, r, w, q);
    check("R4", "status", st, 0);
    check("R4", "ppn", p, 32'h1ABCD);
    check("R1", "reads", r, 1);
    check("R1", "read addr", last_raddr, 32'h20C);
    check("R5", "writes", w, 1);
    check("R5", "wb addr", last_waddr, 32'h20C);
    check("R5", "wb data", mem[slot(3) >> 2], pte(1, 0, 1, 0, 21'h1ABCD));
    walk(3, 0, 0, st, p, r, w, q);
    check("R7", "read ref set no wb", w, 0);
    check("R4", "ppn again", p, 32'h1ABCD);
  endtask

  task automatic t_write_dirty();
    logic [1:0] st; logic [PPN_W-1:0] p; int r, w, q;
    mem[slot(5) >> 2] = pte(1, 0, 1, 0, 21'h00077);
    walk(5, 1, 0, st, p, r, w, q);
    check("R6", "status", st, 0);
    check("R6", "writes", w, 1);
    check("R6", "dirty wb", mem[slot(5) >> 2], pte(1, 1, 1, 0, 21'h00077));
    walk(5, 1, 0, st, p, r, w, q);
    check("R7", "write dirty set no wb", w, 0);
    mem[slot(6) >> 2] = pte(1, 0, 0, 0, 21'h00155);
    walk(6, 0, 0, st, p, r, w, q);
    check("R6", "read keeps clean", mem[slot(6) >> 2], pte(1, 0, 1, 0, 21'h00155));
  endtask

  task automatic t_page_fault();
    logic [1:0] st; logic [PPN_W-1:0] p; int r, w, q;
    mem[slot(7) >> 2] = pte(0, 0, 0, 0, 21'h01234);
    walk(7, 0, 0, st, p, r, w, q);
    check("R3", "status", st, 1);
    check("R3", "ppn", p, 0);
    check("R3", "no wb", w, 0);
    check("R3", "irq pulses", q, 1);
    check("R3", "entry kept", mem[slot(7) >> 2], pte(0, 0, 0, 0, 21'h01234));
  endtask

  task automatic t_protect();
    logic [1:0] st; logic [PPN_W-1:0] p; int r, w, q;
    mem[slot(8) >> 2] = pte(1, 0, 1, 1, 21'h00099);
    walk(8, 1, 0, st, p, r, w, q);
    check("R8", "status", st, 2);
    check("R8", "ppn", p, 0);
    check("R8", "no wb", w, 0);
    check("R8", "entry kept", mem[slot(8) >> 2], pte(1, 0, 1, 1, 21'h00099));
    walk(8, 0, 0, st, p, r, w, q);
    check("R8", "read allowed", st, 0);
    check("R8", "read ppn", p, 32'h99);
  endtask

  task automatic t_limit();
    logic [1:0] st; logic [PPN_W-1:0] p; int r, w, q;
    mem[slot(40) >> 2] = pte(1, 0, 1, 0, 21'h00ABC);
    walk(41, 0, 0, st, p, r, w, q);
    check("R2", "over status", st, 3);
    check("R2", "over ppn", p, 0);
    check("R2", "over no mem", r + w, 0);
    walk(40, 0, 0, st, p, r, w, q);
    check("R2", "at limit status", st, 0);
    check("R2", "at limit reads", r, 1);
    check("R1", "at limit addr", last_raddr, 32'h2A0);
  endtask

  task automatic t_stall();
    logic [1:0] st; logic [PPN_W-1:0] p; int r, w, q;
    stall = 1'b1;
    mem[slot(9) >> 2] = pte(1, 0, 0, 0, 21'h003C3);
    walk(9, 1, 3, st, p, r, w, q);
    stall = 1'b0;
    check("R9", "stall status", st, 0);
    check("R9", "stall ppn", p, 32'h3C3);
    check("R9", "stall reads", r, 1);
    check("R9", "stall writes", w, 1);
    check("R6", "stall wb", mem[slot(9) >> 2], pte(1, 1, 1, 0, 21'h003C3));
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_ref();
    t_write_dirty();
    t_page_fault();
    t_protect();
    t_limit();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule